// File: doc/BRIEF.md
# Cache-Line Bus Slave Memory

This block is a memory that sits on a 64-bit processor local bus as a slave and serves the data-side requests of a processor cache unit. A request is presented on a set of request pins: a 32-bit address, a direction, one size bit choosing a single word or an eight-word line, eight byte enables, four storage-attribute flags, a 2-bit priority and an abort line. The slave accepts a request with an address-acknowledge pulse. It then moves data one 64-bit beat per cycle, marking each beat with a read-data or write-data acknowledge.

A word transfer is one beat. Its byte enables must pick one to four adjacent bytes inside a single 32-bit half of the 64-bit bus. Any other enable pattern is reported on an error pulse, and the transfer completes with no memory change. A line transfer is four beats, starting at the 32-byte aligned address and moving upward; its byte enables are ignored. Only one request is in flight at a time. An abort, which the master raises only while it is in reset, drops a pending or accepted request at once. The attribute flags and the priority are accepted but never change the result.

Top module: `line_slave_mem`

## Requirements
- R1: After reset no acknowledge is asserted, `slaveWide` is 1 (the slave reports a 64-bit width), and every memory entry reads as zero.
- R2: While idle, `addrAck` is high in the same cycle that `reqValid` is high and `reqAbort` is low. Address, direction, size and byte enables are taken from that cycle only; later changes on those pins have no effect on the transfer.
- R3: A word read (`reqLine`=0, `reqRead`=1) gives exactly one `rdAck`, in the cycle after `addrAck`. `rdData` is then the 64-bit entry selected by address bits [8:3].
- R4: A word write gives exactly one `wrAck`, in the cycle after `addrAck`. Byte enable bit i governs `wrData` bits [8i+7:8i]. Only enabled lanes of the entry at address bits [8:3] change.
- R5: A word-transfer byte-enable pattern is legal only if it is nonzero, lies wholly in bits [3:0] or wholly in bits [7:4], and has its ones adjacent. For any other pattern, `beErr` is high together with `addrAck`, the transfer still ends with its single data acknowledge, and a write changes no byte.
- R6: A line read (`reqLine`=1) gives four `rdAck` beats on consecutive cycles after `addrAck`. Beat k returns entry {address bits [8:5], k}, so address bits [4:0] are ignored and the order is ascending.
- R7: A line write gives four consecutive `wrAck` beats. It writes all eight bytes of entry {address bits [8:5], k} from beat k and ignores the byte enables.
- R8: While a transfer is in progress, `addrAck` stays low even when `reqValid` is high. A new request can be accepted only after the last data acknowledge.
- R9: With `reqAbort` high, no acknowledge of any kind is given in that cycle. An accepted transfer is dropped at once, with no further data beats and no write for the aborted beat or any later beat.
- R10: The attribute inputs (`reqCacheable`, `reqWriteThru`, `reqGuarded`, `reqUserAttr`, `reqPriority`) have no effect on acknowledges, read data or memory contents.
- R11: `rdAck` and `wrAck` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Byte address of the request |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqLine | input | 1 | Size bit: 1 = eight-word line, 0 = single word |
| reqByteEn | input | 8 | Byte lane enables for word transfers |
| reqCacheable | input | 1 | Cacheable attribute (no effect) |
| reqWriteThru | input | 1 | Write-through attribute (no effect) |
| reqGuarded | input | 1 | Guarded attribute (no effect) |
| reqUserAttr | input | 1 | User-defined attribute (no effect) |
| reqPriority | input | 2 | Request priority (no effect) |
| reqAbort | input | 1 | Drop the pending or accepted request |
| addrAck | output | 1 | Request accepted |
| rdData | output | 64 | Read beat data |
| rdAck | output | 1 | Read beat valid |
| wrData | input | 64 | Write beat data |
| wrAck | output | 1 | Write beat taken |
| slaveWide | output | 1 | Width report: 1 = 64-bit slave |
| beErr | output | 1 | Illegal word byte-enable pattern seen at accept |

## Verification
Random word and line reads and writes hit random addresses, with unaligned line addresses and random attributes. The byte enables come half from legal single-half runs and half from arbitrary bytes. A reference memory in the bench therefore separates correct lane masking from whole-word writes, illegal patterns from legal ones, and aligned ascending line order from any other beat order. Directed cases add the empty, straddling and gapped enable patterns, a line write with zero enables, and aborts in idle, on the first beat and in the middle of a burst. Throughout each burst the request pins are changed and `reqValid` is held high, which exposes re-sampling of the request and a second acceptance while a transfer is in flight.

// File: rtl/line_slave_pkg.sv
`timescale 1ns/1ps
package line_slave_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the request fields
    logic advance;   // step to the next beat
    logic writeEn;   // commit the current write beat
  } dpStrobe_t;

  // one run of adjacent ones, nonzero
  function automatic logic nibbleRun(input logic [3:0] nib);
    logic [4:0] lowBit;
    logic [4:0] sum;
    lowBit = {1'b0, nib & (~nib + 4'd1)};
    sum    = {1'b0, nib} + lowBit;
    return (nib != 4'd0) && ((sum & {1'b0, nib}) == 5'd0);
  endfunction

  function automatic logic byteEnLegal(input logic [7:0] be);
    return ((be[7:4] == 4'd0) && nibbleRun(be[3:0])) ||
           ((be[3:0] == 4'd0) && nibbleRun(be[7:4]));
  endfunction

endpackage

// File: rtl/line_slave_ctrl.sv
`timescale 1ns/1ps
module line_slave_ctrl
  import line_slave_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqAbort,
  input  logic      lastBeat,
  input  logic      isRead,
  output logic      addrAck,
  output logic      rdAck,
  output logic      wrAck,
  output dpStrobe_t strobe
);

  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    addrAck   = 1'b0;
    rdAck     = 1'b0;
    wrAck     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid && !reqAbort) begin
          addrAck        = 1'b1;
          strobe.capture = 1'b1;
          nextState      = ST_DATA;
        end
      end
      ST_DATA: begin
        if (reqAbort) begin
          nextState = ST_IDLE;
        end else begin
          strobe.advance = 1'b1;
          strobe.writeEn = !isRead;
          rdAck          = isRead;
          wrAck          = !isRead;
          if (lastBeat) nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/line_slave_dp.sv
`timescale 1ns/1ps
module line_slave_dp
  import line_slave_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int MEM_WORDS  = 64,
  parameter int LINE_BEATS = 4,
  localparam int IDX_W     = $clog2(MEM_WORDS),
  localparam int LANES     = DATA_W / 8,
  localparam int BEAT_W    = $clog2(LINE_BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic              reqRead,
  input  logic              reqLine,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              lastBeat,
  output logic              isRead,
  output logic              beErr
);

  logic [IDX_W-1:0]  capIdx;
  logic [LANES-1:0]  capBe;
  logic              capLine;
  logic              capBeOk;
  logic [BEAT_W-1:0] beatCnt;
  logic [IDX_W-1:0]  curIdx;
  logic [LANES-1:0]  laneEn;
  logic [DATA_W-1:0] mem [MEM_WORDS];

  // request latch and beat counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capIdx  <= '0;
      capBe   <= '0;
      capLine <= 1'b0;
      capBeOk <= 1'b0;
      isRead  <= 1'b1;
      beatCnt <= '0;
    end else if (strobe.capture) begin
      capIdx  <= reqIdx;
      capBe   <= reqByteEn;
      capLine <= reqLine;
      capBeOk <= byteEnLegal(reqByteEn);
      isRead  <= reqRead;
      beatCnt <= '0;
    end else if (strobe.advance) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assign beErr    = strobe.capture && !reqLine && !byteEnLegal(reqByteEn);
  assign lastBeat = !capLine || (beatCnt == BEAT_W'(LINE_BEATS - 1));
  assign curIdx   = capLine ? {capIdx[IDX_W-1:BEAT_W], beatCnt} : capIdx;

  // lane enables: full beat on lines, masked word otherwise
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneEn[g] = capLine || (capBeOk && capBe[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (strobe.writeEn) begin
      for (int b = 0; b < LANES; b++) begin
        if (laneEn[b]) mem[curIdx][8*b +: 8] <= wrData[8*b +: 8];
      end
    end
  end

  assign rdData = mem[curIdx];

endmodule

// File: rtl/line_slave_mem.sv
`timescale 1ns/1ps
module line_slave_mem
  import line_slave_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int MEM_WORDS  = 64,
  parameter int LINE_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRead,
  input  logic              reqLine,
  input  logic [7:0]        reqByteEn,
  input  logic              reqCacheable,
  input  logic              reqWriteThru,
  input  logic              reqGuarded,
  input  logic              reqUserAttr,
  input  logic [1:0]        reqPriority,
  input  logic              reqAbort,
  output logic              addrAck,
  output logic [DATA_W-1:0] rdData,
  output logic              rdAck,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAck,
  output logic              slaveWide,
  output logic              beErr
);

  localparam int OFF_W   = $clog2(DATA_W / 8);
  localparam int IDX_W   = $clog2(MEM_WORDS);
  localparam int ADDR_HI = OFF_W + IDX_W;

  dpStrobe_t strobe;
  logic      lastBeat;
  logic      isRead;
  logic      unusedAttrs;

  // attributes are accepted and deliberately left without effect
  assign unusedAttrs = ^{reqCacheable, reqWriteThru, reqGuarded, reqUserAttr,
                         reqPriority, reqAddr[ADDR_W-1:ADDR_HI], reqAddr[OFF_W-1:0]};

  assign slaveWide = (DATA_W == 64);

  line_slave_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAbort (reqAbort),
    .lastBeat (lastBeat),
    .isRead   (isRead),
    .addrAck  (addrAck),
    .rdAck    (rdAck),
    .wrAck    (wrAck),
    .strobe   (strobe)
  );

  line_slave_dp #(
    .DATA_W     (DATA_W),
    .MEM_WORDS  (MEM_WORDS),
    .LINE_BEATS (LINE_BEATS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqIdx    (reqAddr[ADDR_HI-1:OFF_W]),
    .reqRead   (reqRead),
    .reqLine   (reqLine),
    .reqByteEn (reqByteEn),
    .wrData    (wrData),
    .rdData    (rdData),
    .lastBeat  (lastBeat),
    .isRead    (isRead),
    .beErr     (beErr)
  );

endmodule

// File: rtl/line_slave_chk.sv
`timescale 1ns/1ps
module line_slave_chk #(
  parameter int LINE_BEATS = 4,
  localparam int BEAT_W    = $clog2(LINE_BEATS)
) (
  input logic clk,
  input logic rstN,
  input logic reqLine,
  input logic reqAbort,
  input logic addrAck,
  input logic rdAck,
  input logic wrAck,
  input logic beErr
);

  logic            busy;
  logic            lineCap;
  logic [BEAT_W:0] cnt;
  logic            dataAck;

  assign dataAck = rdAck || wrAck;

  // independent tracker of the transfer in flight
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      lineCap <= 1'b0;
      cnt     <= '0;
    end else if (addrAck) begin
      busy    <= 1'b1;
      lineCap <= reqLine;
      cnt     <= '0;
    end else if (busy && reqAbort) begin
      busy <= 1'b0;
    end else if (dataAck) begin
      cnt <= cnt + 1'b1;
      if (!lineCap || cnt == (BEAT_W+1)'(LINE_BEATS - 1)) busy <= 1'b0;
    end
  end

  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |-> !busy);

  p_data_needs_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    dataAck |-> busy);

  p_word_one_beat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lineCap && dataAck) |=> !dataAck);

  p_line_beat_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataAck |-> (cnt < (BEAT_W+1)'(LINE_BEATS)));

  p_abort_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqAbort |-> !(addrAck || rdAck || wrAck));

  p_be_err_at_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    beErr |-> (addrAck && !reqLine));

  p_ack_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rdAck, wrAck}) <= 1);

endmodule

bind line_slave_mem line_slave_chk #(.LINE_BEATS(LINE_BEATS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqLine  (reqLine),
  .reqAbort (reqAbort),
  .addrAck  (addrAck),
  .rdAck    (rdAck),
  .wrAck    (wrAck),
  .beErr    (beErr)
);

// File: tb/line_slave_mem_tb.sv
`timescale 1ns/1ps
module line_slave_mem_tb;

  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqRead, reqLine, reqAbort;
  logic [31:0] reqAddr;
  logic [7:0]  reqByteEn;
  logic        reqCacheable, reqWriteThru, reqGuarded, reqUserAttr;
  logic [1:0]  reqPriority;
  logic        addrAck, rdAck, wrAck, slaveWide, beErr;
  logic [63:0] rdData, wrData;

  logic [63:0] refMem [64];
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  line_slave_mem u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqRead(reqRead), .reqLine(reqLine), .reqByteEn(reqByteEn),
    .reqCacheable(reqCacheable), .reqWriteThru(reqWriteThru),
    .reqGuarded(reqGuarded), .reqUserAttr(reqUserAttr),
    .reqPriority(reqPriority), .reqAbort(reqAbort), .addrAck(addrAck),
    .rdData(rdData), .rdAck(rdAck), .wrData(wrData), .wrAck(wrAck),
    .slaveWide(slaveWide), .beErr(beErr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit refBeOk(input logic [7:0] be);
    case (be)
      8'h01, 8'h02, 8'h04, 8'h08, 8'h03, 8'h06, 8'h0C, 8'h07, 8'h0E, 8'h0F,
      8'h10, 8'h20, 8'h40, 8'h80, 8'h30, 8'h60, 8'hC0, 8'h70, 8'hE0, 8'hF0:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] mergeBytes(input logic [63:0] oldV,
      input logic [63:0] newV, input logic [7:0] be);
    logic [63:0] r = oldV;
    for (int b = 0; b < 8; b++) if (be[b]) r[8*b +: 8] = newV[8*b +: 8];
    return r;
  endfunction

  function automatic int beatIdx(input logic [31:0] addr, input bit line, input int k);
    if (line) return int'({addr[8:5], 2'(k)});
    return int'(addr[8:3]);
  endfunction

  function automatic logic [7:0] legalBe();
    int len = 1 + int'($urandom % 4);
    int st  = int'($urandom % (5 - len));
    logic [3:0] nib = 4'(((1 << len) - 1) << st);
    return ($urandom % 2) ? {nib, 4'h0} : {4'h0, nib};
  endfunction

  task automatic randAttrs();
    reqCacheable = 1'($urandom); reqWriteThru = 1'($urandom);
    reqGuarded   = 1'($urandom); reqUserAttr  = 1'($urandom);
    reqPriority  = 2'($urandom);
  endtask

  // one transfer; abortBeat < 0 means no abort
  task automatic runXfer(input bit isRd, input bit line, input logic [31:0] addr,
                         input logic [7:0] be, input int abortBeat, input bit holdValid);
    int beats = line ? 4 : 1;
    @(negedge clk);
    reqValid = 1'b1; reqRead = isRd; reqLine = line; reqAddr = addr;
    reqByteEn = be; reqAbort = 1'b0; randAttrs();
    #1;
    check(addrAck === 1'b1, "R2 accept", 64'(addrAck), 64'd1);
    check(beErr === (!line && !refBeOk(be)), "R5 beErr", 64'(beErr),
          64'(!line && !refBeOk(be)));
    for (int k = 0; k < beats; k++) begin
      int idx = beatIdx(addr, line, k);
      @(negedge clk);
      reqValid = holdValid;
      reqAddr = $urandom; reqByteEn = 8'($urandom); reqLine = 1'($urandom);
      reqRead = 1'($urandom); randAttrs();
      wrData = {$urandom, $urandom};
      if (k == abortBeat) begin
        reqAbort = 1'b1;
        #1;
        check(!rdAck && !wrAck && !addrAck, "R9 abort beat",
              64'({addrAck, rdAck, wrAck}), 64'd0);
        @(negedge clk);
        reqAbort = 1'b0; reqValid = 1'b0;
        #1;
        check(!rdAck && !wrAck, "R9 after abort", 64'({rdAck, wrAck}), 64'd0);
        return;
      end
      #1;
      if (holdValid) check(addrAck === 1'b0, "R8 no second accept", 64'(addrAck), 64'd0);
      check(!(rdAck && wrAck), "R11 exclusive", 64'({rdAck, wrAck}), 64'b01);
      if (isRd) begin
        check(rdAck === 1'b1, line ? "R6 line rdAck" : "R3 word rdAck", 64'(rdAck), 64'd1);
        check(rdData === refMem[idx], line ? "R6 line data" : "R3 word data",
              rdData, refMem[idx]);
      end else begin
        check(wrAck === 1'b1, line ? "R7 line wrAck" : "R4 word wrAck", 64'(wrAck), 64'd1);
        if (line) refMem[idx] = wrData;
        else if (refBeOk(be)) refMem[idx] = mergeBytes(refMem[idx], wrData, be);
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    check(!rdAck && !wrAck, line ? "R6 burst ends" : "R3 single beat",
          64'({rdAck, wrAck}), 64'd0);
  endtask

  task automatic readBack(input logic [31:0] addr, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqRead = 1'b1; reqLine = 1'b0; reqAddr = addr;
    reqByteEn = 8'hFF; reqAbort = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    check(rdAck && rdData === refMem[addr[8:3]], req, rdData, refMem[addr[8:3]]);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rstN = 1'b0; reqValid = 1'b0; reqRead = 1'b0; reqLine = 1'b0; reqAbort = 1'b0;
    reqAddr = '0; reqByteEn = '0; wrData = '0;
    reqCacheable = 0; reqWriteThru = 0; reqGuarded = 0; reqUserAttr = 0; reqPriority = 0;
    for (int i = 0; i < 64; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(!addrAck && !rdAck && !wrAck, "R1 no acks", 64'({addrAck, rdAck, wrAck}), 64'd0);
    check(slaveWide === 1'b1, "R1 width", 64'(slaveWide), 64'd1);
    runXfer(1, 1, 32'h0000_0040, 8'h00, -1, 0);   // R1 zero contents
    // R4 word writes on both halves and middle lanes
    runXfer(0, 0, 32'h0000_0008, 8'h0F, -1, 1);
    runXfer(0, 0, 32'h0000_0008, 8'hF0, -1, 0);
    runXfer(0, 0, 32'h0000_0010, 8'h06, -1, 1);
    runXfer(0, 0, 32'h0000_0010, 8'h80, -1, 0);
    readBack(32'h0000_0008, "R4 lanes both halves");
    readBack(32'h0000_0010, "R4 partial lanes");
    // R5 illegal patterns: straddle, gap, empty
    runXfer(0, 0, 32'h0000_0010, 8'h18, -1, 0);
    runXfer(0, 0, 32'h0000_0010, 8'h05, -1, 0);
    runXfer(0, 0, 32'h0000_0010, 8'h00, -1, 1);
    readBack(32'h0000_0010, "R5 no write");
    // R7 line write with zero enables, unaligned address; R6 readback ascending
    runXfer(0, 1, 32'h0000_004C, 8'h00, -1, 1);
    runXfer(1, 1, 32'h0000_005B, 8'hAA, -1, 1);
    // R9 abort in idle
    @(negedge clk);
    reqValid = 1'b1; reqAbort = 1'b1; reqRead = 1'b0;
    #1;
    check(addrAck === 1'b0, "R9 idle abort", 64'(addrAck), 64'd0);
    @(negedge clk);
    reqValid = 1'b0; reqAbort = 1'b0;
    // R9 aborts mid line write and on first read beat
    runXfer(0, 1, 32'h0000_0080, 8'hFF, 2, 0);
    runXfer(1, 1, 32'h0000_0080, 8'hFF, 0, 1);
    runXfer(1, 1, 32'h0000_0080, 8'hFF, -1, 0);
    // R10 same read under opposite attributes
    for (int a = 0; a < 2; a++) begin
      @(negedge clk);
      reqValid = 1'b1; reqRead = 1'b1; reqLine = 1'b0; reqAddr = 32'h0000_0088;
      reqByteEn = 8'h0F; reqCacheable = 1'(a); reqWriteThru = 1'(a);
      reqGuarded = 1'(a); reqUserAttr = 1'(a); reqPriority = 2'(a * 3);
      #1;
      check(addrAck === 1'b1, "R10 accept with attrs", 64'(addrAck), 64'd1);
      @(negedge clk);
      reqValid = 1'b0;
      #1;
      check(rdAck && rdData === refMem[17], "R10 data with attrs", rdData, refMem[17]);
    end
    // random mix
    for (int n = 0; n < 400; n++) begin
      bit rd = 1'($urandom);
      bit ln = ($urandom % 3) == 0;
      logic [7:0] be = ($urandom % 2) ? legalBe() : 8'($urandom);
      int ab = (($urandom % 16) == 0) ? int'($urandom % (ln ? 4 : 1)) : -1;
      runXfer(rd, ln, $urandom, be, ab, 1'($urandom));
    end
    for (int i = 0; i < 64; i++) readBack(32'(i * 8), "R4 R7 final contents");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule